// File: doc/BRIEF.md
# Task-Graph Traffic Emulation Node

This block stands in for a processing element on a mesh network-on-chip when only the traffic matters and the computation does not. The node waits until enough packets have reached it from each of its configured upstream peers. It then stays busy for a configured number of cycles in place of real work. After that it emits a configured number of fixed-length packets to each of its enabled downstream peers, and then goes back to waiting. The upstream peers are up to `NSRC` source coordinates, each with its own packet threshold. The downstream peers are up to `NDST` destination slots. Injection is driven by the traffic that arrives, so any delay inside the network carries through to later messages.

A node flagged as the root of the task graph leaves reset already busy. If its thresholds are all zero, it repeats the busy-then-send cycle without any input. Its processing delay therefore sets its injection rate. Packets that arrive while the node is busy or sending are kept for the next round. The configuration arrives on static input ports that the surrounding register file drives.

Top module: `tgpe_node`

## Requirements
- R1: After reset a node with `cfg_root` high reports `st_busy`=1, `st_idle`=0. A node with `cfg_root` low reports `st_idle`=1, `st_busy`=0. `tx_valid` is 0 in both cases.
- R2: A received flit counts for source slot i only if four things hold: `rx_valid` and `rx_head` are both 1, bits [3*CW-1:2*CW] and [4*CW-1:3*CW] equal source i's x and y, and bits [CW-1:0] and [2*CW-1:CW] equal the node's own x and y. Data flits and misaddressed or unknown-source heads are ignored. The node leaves waiting on the clock edge after the one that makes every slot's count reach its threshold (a threshold of 0 is always met).
- R3: Processing lasts max(P,1) cycles, where P is `cfg_proc`. The first flit is then offered, unless destination slot 0 is disabled, in which case it comes one cycle later.
- R4: The send phase walks the destination slots in ascending index. It sends `cfg_pkts` packets of `PKT_LEN` flits to each enabled slot, and each disabled slot costs one idle cycle. A head flit holds dest x in [CW-1:0], dest y in [2*CW-1:CW], own x in [3*CW-1:2*CW] and own y in [4*CW-1:3*CW], with `tx_head`=1. Data flit k (k=1..PKT_LEN-1) holds the value k. `tx_last` marks flit PKT_LEN-1.
- R5: A flit transfers on a cycle with `tx_valid` and `tx_ready` both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_flit` hold steady.
- R6: The node returns to waiting on the edge that transfers the final flit, plus one cycle if the last slot is disabled. With `cfg_pkts`=0 the send phase emits no flit and lasts `NDST` cycles.
- R7: All source counters clear when processing starts. Qualifying heads that arrive during processing or sending count toward the next round, so the node can start a new round at once. Without them it stays waiting.
- R8: A root node with all thresholds zero repeats its rounds: waiting for one cycle, then processing and sending again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_root | input | 1 | Node holds the root task |
| cfg_my_x | input | CW | Own x coordinate |
| cfg_my_y | input | CW | Own y coordinate |
| cfg_src_x | input | NSRC*CW | Expected source x coordinates, slot i at [i*CW +: CW] |
| cfg_src_y | input | NSRC*CW | Expected source y coordinates |
| cfg_need | input | NSRC*CNT_W | Packet threshold per source slot |
| cfg_proc | input | CNT_W | Processing delay P in cycles |
| cfg_pkts | input | CNT_W | Packets sent to each enabled destination |
| cfg_dst_x | input | NDST*CW | Destination x coordinates |
| cfg_dst_y | input | NDST*CW | Destination y coordinates |
| cfg_dst_en | input | NDST | Destination slot enables |
| rx_valid | input | 1 | Received flit valid |
| rx_head | input | 1 | Received flit is a head flit |
| rx_flit | input | 4*CW | Received flit |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Network accepts the outgoing flit |
| tx_head | output | 1 | Outgoing flit is a head flit |
| tx_last | output | 1 | Outgoing flit ends its packet |
| tx_flit | output | 4*CW | Outgoing flit |
| st_idle | output | 1 | Node is waiting for data |
| st_busy | output | 1 | Node is processing or sending |

## Verification
The assertions assume that the configuration ports stay constant whenever reset is released. Under that assumption the measured processing length and the dependency gate are well defined. The bench meets this by changing the configuration only while reset is asserted. The handshake hold check relies on `tx_ready` being the only thing that holds back a transfer. The bench toggles `tx_ready` in a fixed pattern and never touches the configuration during a send.

// File: rtl/tgpe_pkg.sv
package tgpe_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_PROC = 2'd1,
    PH_SEND = 2'd2
  } phase_e;

endpackage

// File: rtl/tgpe_dep_track.sv
module tgpe_dep_track #(
  parameter int NSRC  = 4,
  parameter int CW    = 4,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic                  rx_head,
  input  logic [4*CW-1:0]       rx_flit,
  input  logic [CW-1:0]         my_x,
  input  logic [CW-1:0]         my_y,
  input  logic [NSRC*CW-1:0]    src_x,
  input  logic [NSRC*CW-1:0]    src_y,
  input  logic [NSRC*CNT_W-1:0] need,
  input  logic                  clr,
  output logic                  dep_met
);

  logic            for_me;
  logic [NSRC-1:0] met_vec;

  assign for_me = rx_valid && rx_head &&
                  (rx_flit[0 +: CW] == my_x) && (rx_flit[CW +: CW] == my_y);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic             hit;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign hit = for_me &&
                 (rx_flit[2*CW +: CW] == src_x[i*CW +: CW]) &&
                 (rx_flit[3*CW +: CW] == src_y[i*CW +: CW]);

    always_comb begin
      cnt_d = cnt_q;
      if (clr)                       cnt_d = {{(CNT_W-1){1'b0}}, hit};
      else if (hit && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign met_vec[i] = (cnt_q >= need[i*CNT_W +: CNT_W]);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (cnt_q <= CNT_W'(1)));
  end

  assign dep_met = &met_vec;

endmodule

// File: rtl/tgpe_proc_timer.sv
module tgpe_proc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] tmr_q, tmr_d;

  assign done = run && (({1'b0, tmr_q} + 1'b1) >= {1'b0, limit});

  always_comb begin
    tmr_d = tmr_q;
    if (!run)      tmr_d = '0;
    else if (!done) tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

endmodule

// File: rtl/tgpe_pkt_tx.sv
module tgpe_pkt_tx #(
  parameter int NDST    = 4,
  parameter int CW      = 4,
  parameter int CNT_W   = 8,
  parameter int PKT_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic [CW-1:0]        my_x,
  input  logic [CW-1:0]        my_y,
  input  logic [NDST*CW-1:0]   dst_x,
  input  logic [NDST*CW-1:0]   dst_y,
  input  logic [NDST-1:0]      dst_en,
  input  logic [CNT_W-1:0]     pkts,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic                 tx_head,
  output logic                 tx_last,
  output logic [4*CW-1:0]      tx_flit,
  output logic                 done
);

  localparam int DW  = (NDST > 1) ? $clog2(NDST) : 1;
  localparam int FW  = $clog2(PKT_LEN);
  localparam int PAY = PKT_LEN - 1;
  localparam int FLW = 4 * CW;

  logic [DW-1:0]    d_q, d_d;
  logic [CNT_W-1:0] k_q, k_d;
  logic [FW-1:0]    f_q, f_d;
  logic             slot_on, fire, skip, pkt_end, slot_end;

  assign slot_on  = dst_en[d_q] && (pkts != '0);
  assign tx_valid = active && slot_on;
  assign fire     = tx_valid && tx_ready;
  assign skip     = active && !slot_on;
  assign pkt_end  = fire && (f_q == FW'(PAY));
  assign slot_end = skip || (pkt_end && (k_q == pkts - 1'b1));
  assign done     = slot_end && (d_q == DW'(NDST - 1));

  always_comb begin
    d_d = d_q;
    k_d = k_q;
    f_d = f_q;
    if (!active) begin
      d_d = '0;
      k_d = '0;
      f_d = '0;
    end else if (slot_end) begin
      d_d = d_q + 1'b1;
      k_d = '0;
      f_d = '0;
    end else if (pkt_end) begin
      k_d = k_q + 1'b1;
      f_d = '0;
    end else if (fire) begin
      f_d = f_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      k_q <= '0;
      f_q <= '0;
    end else begin
      d_q <= d_d;
      k_q <= k_d;
      f_q <= f_d;
    end
  end

  assign tx_head = (f_q == '0);
  assign tx_last = (f_q == FW'(PAY));

  always_comb begin
    if (f_q == '0) begin
      tx_flit = {my_y, my_x, dst_y[d_q*CW +: CW], dst_x[d_q*CW +: CW]};
    end else begin
      tx_flit = FLW'(f_q);
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

endmodule

// File: rtl/tgpe_node.sv
module tgpe_node
  import tgpe_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int NDST    = 4,
  parameter int CW      = 4,
  parameter int CNT_W   = 8,
  parameter int PKT_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_root,
  input  logic [CW-1:0]         cfg_my_x,
  input  logic [CW-1:0]         cfg_my_y,
  input  logic [NSRC*CW-1:0]    cfg_src_x,
  input  logic [NSRC*CW-1:0]    cfg_src_y,
  input  logic [NSRC*CNT_W-1:0] cfg_need,
  input  logic [CNT_W-1:0]      cfg_proc,
  input  logic [CNT_W-1:0]      cfg_pkts,
  input  logic [NDST*CW-1:0]    cfg_dst_x,
  input  logic [NDST*CW-1:0]    cfg_dst_y,
  input  logic [NDST-1:0]       cfg_dst_en,
  input  logic                  rx_valid,
  input  logic                  rx_head,
  input  logic [4*CW-1:0]       rx_flit,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic                  tx_head,
  output logic                  tx_last,
  output logic [4*CW-1:0]       tx_flit,
  output logic                  st_idle,
  output logic                  st_busy
);

  phase_e ph_q, ph_d;
  logic   dep_met, clr, proc_done, tx_fin;

  assign clr = (ph_q == PH_WAIT) && dep_met;

  tgpe_dep_track #(.NSRC(NSRC), .CW(CW), .CNT_W(CNT_W)) u_dep (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_head(rx_head), .rx_flit(rx_flit),
    .my_x(cfg_my_x), .my_y(cfg_my_y),
    .src_x(cfg_src_x), .src_y(cfg_src_y), .need(cfg_need),
    .clr(clr), .dep_met(dep_met)
  );

  tgpe_proc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .run(ph_q == PH_PROC), .limit(cfg_proc), .done(proc_done)
  );

  tgpe_pkt_tx #(.NDST(NDST), .CW(CW), .CNT_W(CNT_W), .PKT_LEN(PKT_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(ph_q == PH_SEND),
    .my_x(cfg_my_x), .my_y(cfg_my_y),
    .dst_x(cfg_dst_x), .dst_y(cfg_dst_y), .dst_en(cfg_dst_en),
    .pkts(cfg_pkts), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_head(tx_head), .tx_last(tx_last),
    .tx_flit(tx_flit), .done(tx_fin)
  );

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_WAIT: if (dep_met)   ph_d = PH_PROC;
      PH_PROC: if (proc_done) ph_d = PH_SEND;
      PH_SEND: if (tx_fin)    ph_d = PH_WAIT;
      default:                ph_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= cfg_root ? PH_PROC : PH_WAIT;
    else        ph_q <= ph_d;
  end

  assign st_idle = (ph_q == PH_WAIT);
  assign st_busy = !st_idle;

  // Checker-side count of cycles spent processing.
  logic [CNT_W:0] chk_plen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_plen <= '0;
    else if (ph_q == PH_PROC) chk_plen <= chk_plen + 1'b1;
    else                     chk_plen <= '0;
  end

  // R2
  dep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PROC && $past(ph_q) == PH_WAIT) |-> $past(dep_met));

  // R3
  proc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SEND && $past(ph_q) == PH_PROC) |->
      (($past(chk_plen) + 1'b1) ==
       (($past(cfg_proc) == '0) ? (CNT_W+1)'(1) : {1'b0, $past(cfg_proc)})));

  // R4
  tx_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (ph_q == PH_SEND));

endmodule

// File: tb/tgpe_node_bench.sv
`timescale 1ns/1ps
module tgpe_node_bench;

  localparam int NSRC = 2, NDST = 2, CW = 4, CNT_W = 8, PKT_LEN = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst_n;
  logic                  cfg_root;
  logic [CW-1:0]         cfg_my_x, cfg_my_y;
  logic [NSRC*CW-1:0]    cfg_src_x, cfg_src_y;
  logic [NSRC*CNT_W-1:0] cfg_need;
  logic [CNT_W-1:0]      cfg_proc, cfg_pkts;
  logic [NDST*CW-1:0]    cfg_dst_x, cfg_dst_y;
  logic [NDST-1:0]       cfg_dst_en;
  logic                  rx_valid, rx_head;
  logic [4*CW-1:0]       rx_flit;
  logic                  tx_valid, tx_ready, tx_head, tx_last;
  logic [4*CW-1:0]       tx_flit;
  logic                  st_idle, st_busy;

  tgpe_node #(.NSRC(NSRC), .NDST(NDST), .CW(CW), .CNT_W(CNT_W), .PKT_LEN(PKT_LEN))
  u_tgpe_node (
    .clk(clk), .rst_n(rst_n), .cfg_root(cfg_root),
    .cfg_my_x(cfg_my_x), .cfg_my_y(cfg_my_y),
    .cfg_src_x(cfg_src_x), .cfg_src_y(cfg_src_y), .cfg_need(cfg_need),
    .cfg_proc(cfg_proc), .cfg_pkts(cfg_pkts),
    .cfg_dst_x(cfg_dst_x), .cfg_dst_y(cfg_dst_y), .cfg_dst_en(cfg_dst_en),
    .rx_valid(rx_valid), .rx_head(rx_head), .rx_flit(rx_flit),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_head(tx_head),
    .tx_last(tx_last), .tx_flit(tx_flit),
    .st_idle(st_idle), .st_busy(st_busy)
  );

  // Vector fields: root, need0, need1, proc, pkts, dst mask
  typedef struct packed {
    logic       root;
    logic [3:0] n0;
    logic [3:0] n1;
    logic [7:0] p;
    logic [3:0] d;
    logic [1:0] m;
  } vec_t;

  localparam logic [22:0] TBL [5] = '{
    {1'b1, 4'd0, 4'd0, 8'd3, 4'd1, 2'b11},
    {1'b0, 4'd2, 4'd1, 8'd5, 4'd2, 2'b01},
    {1'b0, 4'd0, 4'd3, 8'd0, 4'd1, 2'b10},
    {1'b0, 4'd1, 4'd1, 8'd4, 4'd0, 2'b11},
    {1'b0, 4'd1, 4'd0, 8'd1, 4'd3, 2'b11}
  };

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_root   = v.root;
    cfg_need   = {4'd0, v.n1, 4'd0, v.n0};
    cfg_proc   = v.p;
    cfg_pkts   = {4'd0, v.d};
    cfg_dst_en = v.m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; rx_head = 1'b0; rx_flit = '0; tx_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic inject(input logic [3:0] sx, input logic [3:0] sy,
                        input logic [3:0] dx, input logic [3:0] dy, input logic hd);
    @(negedge clk);
    rx_valid = 1'b1; rx_head = hd; rx_flit = {sy, sx, dy, dx};
    @(negedge clk);
    rx_valid = 1'b0; rx_head = 1'b0;
    #1;
  endtask

  // Sources: slot0 (1,2), slot1 (3,0); own node (2,1).
  task automatic feed(input int n0, input int n1);
    int tot;
    tot = n0 + n1;
    for (int j = 0; j < tot; j++) begin
      if (j < n0) inject(4'd1, 4'd2, 4'd2, 4'd1, 1'b1);
      else        inject(4'd3, 4'd0, 4'd2, 4'd1, 1'b1);
      chk("R2 still waiting on counting edge", st_idle, 1);
    end
    @(negedge clk); #1;
    chk("R2 leaves waiting after dependency met", st_busy, 1);
  endtask

  task automatic run_round(input int wait_exp, input int d, input logic [1:0] m);
    int n, g, el;
    logic held_v;
    logic [4*CW-1:0] held;
    logic [3:0] dx, dy;
    int expv;
    if (d == 0 || m == 2'b00) begin
      n = 0;
      repeat (wait_exp + NDST + 3) begin
        @(negedge clk); #1;
        if (tx_valid) n++;
      end
      chk("R6 no flit when nothing to send", n, 0);
      chk("R6 back to waiting", st_idle, 1);
      return;
    end
    tx_ready = 1'b0; n = 0;
    while (!tx_valid && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    chk("R3 processing length", n, wait_exp + (m[0] ? 0 : 1));
    held_v = 1'b0; held = '0;
    for (int dd = 0; dd < NDST; dd++) begin
      if (!m[dd]) continue;
      dx = (dd == 0) ? 4'd0 : 4'd3;
      dy = (dd == 0) ? 4'd3 : 4'd1;
      for (int k = 0; k < d; k++) begin
        for (int f = 0; f < PKT_LEN; f++) begin
          g = 0;
          while (g < 100) begin
            @(negedge clk);
            tx_ready = (cyc % 3) != 2; cyc++;
            #1; g++;
            if (held_v) chk("R5 flit held under backpressure", {tx_valid, tx_flit}, {1'b1, held});
            held_v = tx_valid && !tx_ready;
            held   = tx_flit;
            if (tx_valid && tx_ready) break;
          end
          expv = (f == 0) ? {2'b10, 4'd1, 4'd2, dy, dx}
                          : {1'b0, (f == PKT_LEN-1), 16'(f)};
          chk("R4 flit content", {tx_head, tx_last, tx_flit}, expv);
        end
      end
    end
    el = 0;
    @(negedge clk); tx_ready = 1'b0; #1; el++;
    if (!st_idle) begin
      @(negedge clk); #1; el++;
    end
    chk("R6 return to waiting after last flit", el, m[NDST-1] ? 1 : 2);
    chk("R6 idle flag", st_idle, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    cfg_my_x = 4'd2; cfg_my_y = 4'd1;
    cfg_src_x = {4'd3, 4'd1}; cfg_src_y = {4'd0, 4'd2};
    cfg_dst_x = {4'd3, 4'd0}; cfg_dst_y = {4'd1, 4'd3};

    for (int i = 0; i < 5; i++) begin
      v = vec_t'(TBL[i]);
      set_cfg(v);
      do_reset();
      chk("R1 tx_valid low after reset", tx_valid, 0);
      if (v.root) begin
        chk("R1 root starts busy", {st_busy, st_idle}, 2'b10);
        run_round(v.p == 0 ? 1 : int'(v.p), v.d, v.m);
        @(negedge clk); #1;
        chk("R8 root starts next round", st_busy, 1);
        run_round(v.p == 0 ? 1 : int'(v.p), v.d, v.m);
      end else begin
        chk("R1 non-root starts waiting", {st_busy, st_idle}, 2'b01);
        feed(v.n0, v.n1);
        run_round(v.p == 0 ? 1 : int'(v.p), v.d, v.m);
      end
    end

    // R2: data flits, unknown sources and misaddressed heads are ignored
    set_cfg({1'b0, 4'd1, 4'd1, 8'd2, 4'd1, 2'b01});
    do_reset();
    inject(4'd1, 4'd2, 4'd2, 4'd1, 1'b0);
    inject(4'd3, 4'd0, 4'd2, 4'd1, 1'b0);
    inject(4'd5, 4'd5, 4'd2, 4'd1, 1'b1);
    inject(4'd3, 4'd0, 4'd7, 4'd7, 1'b1);
    inject(4'd1, 4'd2, 4'd2, 4'd1, 1'b1);
    repeat (3) @(negedge clk); #1;
    chk("R2 ignored flits and partial dependency keep waiting", st_idle, 1);
    feed(0, 1);
    run_round(2, 1, 2'b01);

    // R7: arrivals during processing carry over; counters clear per round
    set_cfg({1'b0, 4'd1, 4'd1, 8'd8, 4'd1, 2'b11});
    do_reset();
    feed(1, 1);
    inject(4'd1, 4'd2, 4'd2, 4'd1, 1'b1);
    inject(4'd3, 4'd0, 4'd2, 4'd1, 1'b1);
    run_round(4, 1, 2'b11);
    @(negedge clk); #1;
    chk("R7 carried-over data starts next round", st_busy, 1);
    run_round(8, 1, 2'b11);
    repeat (10) @(negedge clk); #1;
    chk("R7 counters cleared, node stays waiting", st_idle, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule